// File: doc/BRIEF.md
# Root Hub Port Status Logic

This block holds the status word of each downstream port of a USB root hub together with the hub-wide status word, and updates them from two sources: device connect and disconnect events reported per port, and 32-bit register writes from the host controller software. A single write word carries both set requests and clear requests. Which bit means what depends on the bit position and on the current port state. For example, enable, suspend and reset requests only take effect on a connected port. On an empty port they turn into a connect-change indication.

Each port keeps connect, enable, suspend, reset, power and low-speed state plus four sticky change flags that software clears by writing ones. A port reset drives a per-port bus-reset request for a programmable number of clocks. When that time ends, the port becomes enabled and reports reset-change. Any change of any port word or of the hub word produces a one-cycle status-change pulse, which feeds the controller's interrupt logic. Reads are combinational on the same address bus as writes.

Top module: `roothub_status`

## Requirements
- R1: After reset every port word reads 0x0000_0100, the hub word reads 0, no bus-reset request is active and the status-change output is low.
- R2: An attach pulse on a port sets connect (bit 0) and connect-change (bit 16) and copies the low-speed input into bit 9.
- R3: A detach pulse clears connect and sets connect-change if connect was set, and clears enable (bit 1) and sets enable-change (bit 17) if enable was set; when attach and detach coincide, detach wins.
- R4: Writing a 1 to connect-change (16), enable-change (17), suspend-change (18) or reset-change (20) clears that flag; the overcurrent bits 3 and 19 always read 0.
- R5: Writing a 1 to bit 0 of a port clears its enable bit; a set request for enable in the same word is applied afterwards.
- R6: Writing a 1 to enable (1), suspend (2) or reset (4) sets that bit when the port is connected; on a disconnected port the same write sets connect-change instead.
- R7: A reset request holds bit 4 and the port's bus-reset output high for exactly RST_CYCLES clocks, then clears bit 4 and sets enable and reset-change (bit 20); a repeated reset write during a running reset does not restart it.
- R8: Writing bit 9 of a port powers it off, clearing power, connect, suspend and reset; writing bit 8 powers it on; with both bits in one word the port ends up powered.
- R9: A hub write with bit 0 powers every port off and a hub write with bit 16 powers every port on.
- R10: The hub word is at byte address 0x50; bit 15 written as 1 sets the remote-wakeup enable, bit 31 written as 1 clears it (clear wins), and the enable reads back at bit 15.
- R11: status_chg is high for one clock, in the cycle right after the clock edge at which any port or hub state changed, and stays low when a write or event changes nothing.
- R12: Address 0x48 reads 0x200 ORed with NUM_PORTS; port reads always show bit 8 set; any other address reads 0.
- R13: Port i is at byte address 0x54 + 4*i; a write affects only the addressed word, and misaligned or unmapped writes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| dev_attach | input | NUM_PORTS | Per-port device attach pulse |
| dev_detach | input | NUM_PORTS | Per-port device detach pulse |
| dev_low_speed | input | NUM_PORTS | Speed of the attaching device, 1 = low speed |
| bus_reset_req | output | NUM_PORTS | Per-port bus-reset request |
| status_chg | output | 1 | One-cycle pulse on any port or hub state change |

## Verification
A wrong port state shows up on reg_rdata as soon as the port word is read, in the cycle after the edge that caused it. The same edge produces a missing or extra status_chg pulse, even when the faulty bit is the power bit that reads back as 1. A wrong reset countdown changes the width of bus_reset_req and moves the edge at which enable and reset-change appear. The bench therefore reads every word and compares the pulse and the bus-reset outputs after every clock. Because of this, a fault is reported in the cycle it first becomes visible.

// File: rtl/roothub_pkg.sv
`timescale 1ns/100ps
package roothub_pkg;

    // port word bit positions (software decodes these)
    localparam int PB_CONN     = 0;
    localparam int PB_ENA      = 1;
    localparam int PB_SUSP     = 2;
    localparam int PB_RST      = 4;
    localparam int PB_PWR      = 8;
    localparam int PB_LOW      = 9;
    localparam int PB_CONN_CHG = 16;
    localparam int PB_ENA_CHG  = 17;
    localparam int PB_SUSP_CHG = 18;
    localparam int PB_RST_CHG  = 20;

    // hub word bit positions
    localparam int HB_PWR_OFF  = 0;
    localparam int HB_WAKE_SET = 15;
    localparam int HB_PWR_ON   = 16;
    localparam int HB_WAKE_CLR = 31;

    // descriptor: ports are never individually switched
    localparam int DB_NO_SWITCH = 9;

    // byte addresses
    localparam logic [7:0] ADDR_DESC  = 8'h48;
    localparam logic [7:0] ADDR_HUB   = 8'h50;
    localparam logic [7:0] ADDR_PORT0 = 8'h54;

    typedef struct packed {
        logic conn;
        logic ena;
        logic susp;
        logic rst;
        logic pwr;
        logic low;
        logic conn_chg;
        logic ena_chg;
        logic susp_chg;
        logic rst_chg;
    } port_state_t;

    function automatic logic [31:0] port_image(port_state_t s);
        logic [31:0] w;
        w              = '0;
        w[PB_CONN]     = s.conn;
        w[PB_ENA]      = s.ena;
        w[PB_SUSP]     = s.susp;
        w[PB_RST]      = s.rst;
        w[PB_PWR]      = s.pwr;
        w[PB_LOW]      = s.low;
        w[PB_CONN_CHG] = s.conn_chg;
        w[PB_ENA_CHG]  = s.ena_chg;
        w[PB_SUSP_CHG] = s.susp_chg;
        w[PB_RST_CHG]  = s.rst_chg;
        return w;
    endfunction

endpackage

// File: rtl/roothub_port.sv
`timescale 1ns/100ps
module roothub_port
    import roothub_pkg::*;
#(
    parameter int RST_CYCLES = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        attach,
    input  logic        detach,
    input  logic        low_speed,
    input  logic        wr_hit,
    input  logic [31:0] wdata,
    input  logic        all_off,
    input  logic        all_on,
    output logic [31:0] image,
    output logic        bus_rst,
    output logic        changed
);

    localparam int CW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        port_state_t     st;
        logic [CW-1:0]   cnt;
    } port_regs_t;

    port_regs_t r_q, r_d;
    logic       started;

    function automatic port_state_t power_down(port_state_t s);
        port_state_t o;
        o      = s;
        o.pwr  = 1'b0;
        o.conn = 1'b0;
        o.susp = 1'b0;
        o.rst  = 1'b0;
        return o;
    endfunction

    always_comb begin
        r_d     = r_q;
        started = 1'b0;

        // device events, detach has priority
        if (detach) begin
            if (r_d.st.conn) begin
                r_d.st.conn     = 1'b0;
                r_d.st.conn_chg = 1'b1;
            end
            if (r_d.st.ena) begin
                r_d.st.ena     = 1'b0;
                r_d.st.ena_chg = 1'b1;
            end
        end else if (attach) begin
            r_d.st.conn     = 1'b1;
            r_d.st.conn_chg = 1'b1;
            r_d.st.low      = low_speed;
        end

        // software write
        if (wr_hit) begin
            if (wdata[PB_CONN_CHG]) r_d.st.conn_chg = 1'b0;
            if (wdata[PB_ENA_CHG])  r_d.st.ena_chg  = 1'b0;
            if (wdata[PB_SUSP_CHG]) r_d.st.susp_chg = 1'b0;
            if (wdata[PB_RST_CHG])  r_d.st.rst_chg  = 1'b0;

            if (wdata[PB_CONN]) r_d.st.ena = 1'b0;

            if (wdata[PB_ENA]) begin
                if (r_d.st.conn) r_d.st.ena      = 1'b1;
                else             r_d.st.conn_chg = 1'b1;
            end
            if (wdata[PB_SUSP]) begin
                if (r_d.st.conn) r_d.st.susp     = 1'b1;
                else             r_d.st.conn_chg = 1'b1;
            end
            if (wdata[PB_RST]) begin
                if (r_d.st.conn) begin
                    if (!r_d.st.rst) started = 1'b1;
                    r_d.st.rst = 1'b1;
                end else begin
                    r_d.st.conn_chg = 1'b1;
                end
            end

            // off first, then on: both together leaves the port powered
            if (wdata[PB_LOW]) r_d.st = power_down(r_d.st);
            if (wdata[PB_PWR]) r_d.st.pwr = 1'b1;
        end

        // hub-wide power commands
        if (all_off) r_d.st = power_down(r_d.st);
        if (all_on)  r_d.st.pwr = 1'b1;

        // reset countdown
        if (started) begin
            r_d.cnt = CW'(RST_CYCLES);
        end else if (r_d.st.rst) begin
            if (r_q.cnt == CW'(1)) begin
                r_d.st.rst     = 1'b0;
                r_d.st.ena     = 1'b1;
                r_d.st.rst_chg = 1'b1;
                r_d.cnt        = '0;
            end else begin
                r_d.cnt = r_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign image   = port_image(r_q.st);
    assign bus_rst = r_q.st.rst;
    assign changed = (r_d.st != r_q.st);

endmodule

// File: rtl/roothub_hub.sv
`timescale 1ns/100ps
module roothub_hub
    import roothub_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [31:0] wdata,
    output logic        wake_en,
    output logic        all_off,
    output logic        all_on,
    output logic        changed
);

    logic wake_q, wake_d;

    always_comb begin
        wake_d = wake_q;
        if (wr_hit) begin
            if (wdata[HB_WAKE_SET]) wake_d = 1'b1;
            if (wdata[HB_WAKE_CLR]) wake_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_d;
    end

    assign wake_en = wake_q;
    assign all_off = wr_hit & wdata[HB_PWR_OFF];
    assign all_on  = wr_hit & wdata[HB_PWR_ON];
    assign changed = (wake_d != wake_q);

endmodule

// File: rtl/roothub_rdmux.sv
`timescale 1ns/100ps
module roothub_rdmux
    import roothub_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [7:0]                  addr,
    input  logic [NUM_PORTS-1:0][31:0]  images,
    input  logic                        wake_en,
    output logic [31:0]                 rdata
);

    localparam logic [31:0] DESC_WORD = (32'd1 << DB_NO_SWITCH) | 32'(NUM_PORTS);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_DESC) rdata = DESC_WORD;
        if (addr == ADDR_HUB)  rdata[HB_WAKE_SET] = wake_en;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (addr == 8'(ADDR_PORT0 + 8'(4 * i))) begin
                rdata         = images[i];
                rdata[PB_PWR] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/roothub_status.sv
`timescale 1ns/100ps
module roothub_status
    import roothub_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int RST_CYCLES = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_PORTS-1:0]  dev_attach,
    input  logic [NUM_PORTS-1:0]  dev_detach,
    input  logic [NUM_PORTS-1:0]  dev_low_speed,
    output logic [NUM_PORTS-1:0]  bus_reset_req,
    output logic                  status_chg
);

    logic [NUM_PORTS-1:0][31:0] images;
    logic [NUM_PORTS-1:0]       port_chg;
    logic                       hub_hit, hub_chg, wake_en, all_off, all_on;
    logic                       pulse_d, pulse_q;

    assign hub_hit = reg_wr && (reg_addr == ADDR_HUB);

    roothub_hub u_hub (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hub_hit),
        .wdata   (reg_wdata),
        .wake_en (wake_en),
        .all_off (all_off),
        .all_on  (all_on),
        .changed (hub_chg)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic hit;
        assign hit = reg_wr && (reg_addr == 8'(ADDR_PORT0 + 8'(4 * g)));

        roothub_port #(.RST_CYCLES(RST_CYCLES)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .attach    (dev_attach[g]),
            .detach    (dev_detach[g]),
            .low_speed (dev_low_speed[g]),
            .wr_hit    (hit),
            .wdata     (reg_wdata),
            .all_off   (all_off),
            .all_on    (all_on),
            .image     (images[g]),
            .bus_rst   (bus_reset_req[g]),
            .changed   (port_chg[g])
        );
    end

    roothub_rdmux #(.NUM_PORTS(NUM_PORTS)) u_rdmux (
        .addr    (reg_addr),
        .images  (images),
        .wake_en (wake_en),
        .rdata   (reg_rdata)
    );

    always_comb begin
        pulse_d = (|port_chg) | hub_chg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign status_chg = pulse_q;

endmodule

// File: rtl/roothub_status_chk.sv
`timescale 1ns/100ps
module roothub_status_chk #(
    parameter int NUM_PORTS  = 4,
    parameter int RST_CYCLES = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [7:0]            reg_addr,
    input logic [31:0]           reg_wdata,
    input logic [31:0]           reg_rdata,
    input logic [NUM_PORTS-1:0]  dev_attach,
    input logic [NUM_PORTS-1:0]  dev_detach,
    input logic [NUM_PORTS-1:0]  bus_reset_req,
    input logic                  status_chg
);

    localparam int HW = $clog2(RST_CYCLES + 2) + 1;

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_cnt <= '0;
        else if (!bus_reset_req[0])  hold_cnt <= '0;
        else if (hold_cnt != '1)     hold_cnt <= hold_cnt + HW'(1);
    end

    AST_RST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HW'(RST_CYCLES)); // R7

    AST_RST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_reset_req[0]) |-> $past(reg_wr && reg_wdata[4] && reg_addr == 8'h54)); // R7

    AST_RST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_reset_req[0]) && !$past(reg_wr)) |-> status_chg); // R11

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |-> $past(reg_wr || (|dev_attach) || (|dev_detach) || (|bus_reset_req))); // R11

    AST_HUB_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h50 && $past(reg_addr == 8'h50) && !$past(reg_wr)) |-> $stable(reg_rdata)); // R10

    AST_PORT_PWR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h54) |-> reg_rdata[8]); // R12

endmodule

bind roothub_status roothub_status_chk #(
    .NUM_PORTS  (NUM_PORTS),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .dev_attach    (dev_attach),
    .dev_detach    (dev_detach),
    .bus_reset_req (bus_reset_req),
    .status_chg    (status_chg)
);

// File: tb/test_roothub_status.sv
`timescale 1ns/100ps
module test_roothub_status;

    localparam int NP   = 4;
    localparam int RSTC = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NP-1:0]  dev_attach = '0;
    logic [NP-1:0]  dev_detach = '0;
    logic [NP-1:0]  dev_low_speed = '0;
    logic [NP-1:0]  bus_reset_req;
    logic           status_chg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    roothub_status #(.NUM_PORTS(NP), .RST_CYCLES(RSTC)) i_roothub_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .dev_attach    (dev_attach),
        .dev_detach    (dev_detach),
        .dev_low_speed (dev_low_speed),
        .bus_reset_req (bus_reset_req),
        .status_chg    (status_chg)
    );

    // ---------------- reference model ----------------
    typedef struct packed {
        logic ccs, pes, pss, prs, pps, lsda, csc, pesc, pssc, prsc;
        logic [7:0] cnt;
    } mport_t;

    mport_t m [NP];
    logic   m_wake;
    logic   exp_pulse;

    function automatic logic [31:0] mimg(mport_t s);
        return {11'b0, s.prsc, 1'b0, s.pssc, s.pesc, s.csc, 6'b0, s.lsda, 1'b1,
                3'b0, s.prs, 1'b0, s.pss, s.pes, s.ccs};
    endfunction

    function automatic mport_t moff(mport_t s);
        mport_t o = s;
        o.pps = 0; o.ccs = 0; o.pss = 0; o.prs = 0;
        return o;
    endfunction

    function automatic mport_t mstep(mport_t s, logic att, logic det, logic ls,
                                     logic hit, logic [31:0] wd, logic off, logic on);
        mport_t n = s;
        logic   go = 0;
        if (det) begin
            if (n.ccs) begin n.ccs = 0; n.csc = 1; end
            if (n.pes) begin n.pes = 0; n.pesc = 1; end
        end else if (att) begin
            n.ccs = 1; n.csc = 1; n.lsda = ls;
        end
        if (hit) begin
            if (wd[16]) n.csc = 0;
            if (wd[17]) n.pesc = 0;
            if (wd[18]) n.pssc = 0;
            if (wd[20]) n.prsc = 0;
            if (wd[0]) n.pes = 0;
            if (wd[1]) begin if (n.ccs) n.pes = 1; else n.csc = 1; end
            if (wd[2]) begin if (n.ccs) n.pss = 1; else n.csc = 1; end
            if (wd[4]) begin
                if (n.ccs) begin go = !n.prs; n.prs = 1; end
                else n.csc = 1;
            end
            if (wd[9]) n = moff(n);
            if (wd[8]) n.pps = 1;
        end
        if (off) n = moff(n);
        if (on)  n.pps = 1;
        if (go) n.cnt = 8'(RSTC);
        else if (n.prs) begin
            if (s.cnt == 8'd1) begin
                n.prs = 0; n.pes = 1; n.prsc = 1; n.cnt = 0;
            end else n.cnt = s.cnt - 8'd1;
        end
        return n;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic read_at(logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic compare_all(string tag);
        logic [31:0] v;
        for (int p = 0; p < NP; p++) begin
            read_at(8'(8'h54 + 4 * p), v);
            chk(v == mimg(m[p]), tag, v, mimg(m[p]));
            chk(bus_reset_req[p] == m[p].prs, tag, 32'(bus_reset_req[p]), 32'(m[p].prs));
        end
        read_at(8'h50, v);
        chk(v == (32'(m_wake) << 15), tag, v, 32'(m_wake) << 15);
    endtask

    task automatic tick(string tag);
        logic chg;
        logic off, on, hubw;
        @(posedge clk);
        chg  = 0;
        hubw = reg_wr && reg_addr == 8'h50;
        off  = hubw && reg_wdata[0];
        on   = hubw && reg_wdata[16];
        for (int p = 0; p < NP; p++) begin
            mport_t n;
            logic   hit;
            hit = reg_wr && reg_addr == 8'(8'h54 + 4 * p);
            n = mstep(m[p], dev_attach[p], dev_detach[p], dev_low_speed[p],
                      hit, reg_wdata, off, on);
            if (mimg(n) != mimg(m[p]) || n.pps != m[p].pps) chg = 1;
            m[p] = n;
        end
        if (hubw) begin
            logic w = m_wake;
            if (reg_wdata[15]) w = 1;
            if (reg_wdata[31]) w = 0;
            if (w != m_wake) chg = 1;
            m_wake = w;
        end
        exp_pulse = chg;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0; dev_attach = '0; dev_detach = '0; dev_low_speed = '0;
        chk(status_chg == exp_pulse, {tag, " pulse"}, 32'(status_chg), 32'(exp_pulse));
        compare_all(tag);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(tag);
    endtask

    task automatic attach(int p, logic ls, string tag);
        dev_attach[p] = 1; dev_low_speed[p] = ls;
        tick(tag);
    endtask

    task automatic detach(int p, string tag);
        dev_detach[p] = 1;
        tick(tag);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R13 watchdog act=0 exp=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) m[p] = '0;
        m_wake = 0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(status_chg == 1'b0, "R1 pulse", 32'(status_chg), 0);
        chk(bus_reset_req == '0, "R1 busrst", 32'(bus_reset_req), 0);
        compare_all("R1");

        // R2: attach low and full speed
        attach(0, 1, "R2");
        read_at(8'h54, v);
        chk(v == 32'h0001_0301, "R2 low", v, 32'h0001_0301);
        attach(1, 0, "R2");
        read_at(8'h58, v);
        chk(v == 32'h0001_0101, "R2 full", v, 32'h0001_0101);

        // R6: enable on connected vs disconnected
        wr(8'h54, 32'h2, "R6");
        wr(8'h5C, 32'h2, "R6");
        read_at(8'h5C, v);
        chk(v == 32'h0001_0100, "R6 empty", v, 32'h0001_0100);

        // R5: connect bit clears enable; 0x3 keeps it enabled
        wr(8'h54, 32'h1, "R5");
        read_at(8'h54, v);
        chk(v[1] == 1'b0, "R5 clr", v, v & ~32'h2);
        wr(8'h54, 32'h3, "R5");

        // R4: write-one-to-clear
        wr(8'h54, 32'h001F_0000, "R4");
        read_at(8'h54, v);
        chk(v == 32'h0000_0303, "R4", v, 32'h0000_0303);

        // R11: no-op write gives no pulse
        wr(8'h54, 32'h0, "R11");
        chk(status_chg == 1'b0, "R11 noop", 32'(status_chg), 0);

        // R7: port reset countdown
        wr(8'h54, 32'h10, "R7");
        chk(bus_reset_req[0] == 1'b1, "R7 start", 32'(bus_reset_req), 1);
        wr(8'h54, 32'h10, "R7");
        for (int k = 0; k < RSTC; k++) tick("R7");
        read_at(8'h54, v);
        chk(v == 32'h0010_0303, "R7 done", v, 32'h0010_0303);

        // R6: suspend
        wr(8'h54, 32'h4, "R6");

        // R3: detach of enabled port
        detach(0, "R3");
        read_at(8'h54, v);
        chk(v == 32'h0013_0304, "R3", v, 32'h0013_0304);

        // R3: attach and detach together
        dev_attach[2] = 1; dev_detach[2] = 1;
        tick("R3");

        // R8: power bits
        wr(8'h58, 32'h6, "R8");
        wr(8'h58, 32'h300, "R8");
        wr(8'h58, 32'h200, "R8");
        read_at(8'h58, v);
        chk(v[0] == 1'b0 && v[2] == 1'b0, "R8 off", v, v & ~32'h5);
        wr(8'h58, 32'h100, "R8");
        chk(status_chg == 1'b1, "R8 on pulse", 32'(status_chg), 1);

        // R9: hub-wide power
        attach(3, 0, "R9");
        wr(8'h50, 32'h1, "R9");
        read_at(8'h60, v);
        chk(v[0] == 1'b0, "R9 off", v, v & ~32'h1);
        wr(8'h50, 32'h1_0000, "R9");

        // R10: remote wakeup enable
        wr(8'h50, 32'h8000, "R10");
        read_at(8'h50, v);
        chk(v == 32'h8000, "R10 set", v, 32'h8000);
        wr(8'h50, 32'h8000_8000, "R10");
        read_at(8'h50, v);
        chk(v == 32'h0, "R10 clr", v, 0);

        // R12: descriptor and unmapped reads
        read_at(8'h48, v);
        chk(v == (32'h200 | NP), "R12 desc", v, 32'h200 | NP);
        read_at(8'h00, v);
        chk(v == 32'h0, "R12 unmapped", v, 0);
        read_at(8'h55, v);
        chk(v == 32'h0, "R12 misaligned", v, 0);

        // R13: misaligned / out-of-range writes
        attach(1, 1, "R13");
        wr(8'h59, 32'h001F_0000, "R13");
        wr(8'h64, 32'h001F_0002, "R13");

        // R13: constrained random mix
        for (int it = 0; it < 4000; it++) begin
            int p = int'($urandom_range(NP - 1));
            case ($urandom_range(9))
                0, 1: begin dev_attach[p] = 1; dev_low_speed[p] = 1'($urandom); end
                2:    dev_detach[p] = 1;
                3, 4, 5: begin
                    reg_wr = 1;
                    reg_addr = ($urandom_range(15) == 0) ? 8'(8'h54 + 4 * p + 1)
                                                        : 8'(8'h54 + 4 * p);
                    reg_wdata = $urandom & 32'h001F_0317;
                    if ($urandom_range(3) != 0) reg_wdata[9] = 0;
                end
                6: begin
                    reg_wr = 1; reg_addr = 8'h50;
                    reg_wdata = $urandom & 32'h8001_8001;
                    if ($urandom_range(3) != 0) reg_wdata[0] = 0;
                end
                default: ;
            endcase
            tick("R13");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule